// File: doc/BRIEF.md
# Banked Chip-Select Decoder with Fixed SRAM Timing

This block sits between a processor bus and a set of external memories. Every bus request carries an address. The block checks that address against eight banks that software programs, and it drives the active-low chip select of the one bank that claims the address. Each bank has two 32-bit registers. The base register holds the bank's start address, a valid flag and a two-bit routing field. The option register holds the address mask and a burst-inhibit flag.

A bank whose routing field is 00 is run by the block's own fixed-timing controller, which suits a 32-bit asynchronous SRAM. An access lasts two clocks. A read holds the output enable low for both clocks. A write holds the active-low byte write enables of the addressed lanes low for both clocks. A one-clock transfer acknowledge comes in the second clock.

A bank with any other routing value is handed to an external sequencer. The block gives a start pulse and the routing code, and it holds that bank's chip select until the sequencer reports that it is done. An address that no bank claims selects nothing, and a bus-error pulse follows after a fixed timeout.

Top module: `bank_select_ctrl`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the base register (`cfg_opt`=0) or option register (`cfg_opt`=1) of bank `cfg_idx`. Base register fields: bits 31:12 base address, bits 7:6 routing code, bit 0 valid. Option register fields: bits 31:12 address mask, bit 8 burst-inhibit. Reset clears every register, so that no bank is valid.
- R2: A bank claims a request when its valid bit is 1 and the address bits 31:12, masked by the bank's mask, equal its base bits under the same mask. Address bits 11:0 never affect the decode.
- R3: When several banks claim an address, the bank with the lowest index wins.
- R4: `cs_n` is all ones when the block is idle. During an access, exactly the winning bank's bit is low, for every clock of that access.
- R5: A read to a routing-00 bank drives `oe_n` low for two clocks, starting in the clock after the request is sampled, and keeps `we_n` at 4'b1111.
- R6: A write to a routing-00 bank drives `we_n` low on the addressed lanes for the same two clocks and keeps `oe_n` high. Lanes are big-endian: byte offset k (addr[1:0]) uses lane 3-k, and lane 3 is the most significant byte. `req_size` 0 means one byte, 1 means a halfword at offset 0 or 2, and 2 or 3 means the whole word.
- R7: `xfer_ack` is high for exactly one clock, the second clock of a routing-00 access. In the following clock every chip select is released.
- R8: `burst_refuse` is high together with `xfer_ack` when the request had `req_burst` set and the bank's burst-inhibit bit is 1. Otherwise it stays low. A burst to a routing-00 bank is always ended after the single beat.
- R9: For a bank with a routing code other than 00, `ext_go` pulses high in the first clock of the access. `ext_msel` shows the routing code for the whole access, and the bank's chip select stays low up to and including the clock in which `ext_done` is sampled high. In that access `oe_n`, `we_n` and `xfer_ack` stay inactive, and `ext_msel` is 0 outside such an access.
- R10: A request that no bank claims asserts no chip select. `bus_err` pulses high for one clock, the 16th clock after the request is sampled, and the block is idle again in the next clock.
- R11: A request presented while an access is in progress is ignored. It starts no access and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_opt | input | 1 | 0 selects the base register, 1 selects the option register |
| cfg_idx | input | 3 | Bank index for the register write |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe, sampled while the block is idle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 or 3 word |
| req_burst | input | 1 | Request asks for a burst |
| ext_done | input | 1 | External sequencer finished the current access |
| cs_n | output | 8 | Active-low chip select for each bank |
| oe_n | output | 1 | Active-low SRAM output enable |
| we_n | output | 4 | Active-low byte write enables, lane 3 is the most significant byte |
| xfer_ack | output | 1 | Transfer acknowledge for fixed-timing accesses |
| burst_refuse | output | 1 | Burst request ended as a single beat |
| ext_go | output | 1 | Start pulse for the external sequencer |
| ext_msel | output | 2 | Routing code of the bank handed to the sequencer |
| bus_err | output | 1 | Timeout pulse for an unclaimed address |

## Verification
Reads and writes are sent with every legal size and byte offset. This separates the big-endian lane mapping from a mirrored mapping and shows halfword alignment. Overlapping banks that differ in routing code show which bank wins the priority. A bank that is programmed but left invalid, and addresses whose low 12 bits are set, show that the valid bit and the mask are obeyed. Bursts to banks with and without the inhibit bit, external accesses of several lengths, and a request sent during a busy access each exercise one branch of the control path. A reference model that keeps its own schedule of expected outputs is compared with every port on every clock.

// File: rtl/bank_select_ctrl.sv
module bank_select_ctrl #(
  parameter int NBANK = 8,
  parameter int AW = 32,
  parameter int PAGE_LSB = 12,
  parameter int MISS_CYCLES = 16,
  localparam int IDXW = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_opt,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic             req_burst,
  input  logic             ext_done,
  output logic [NBANK-1:0] cs_n,
  output logic             oe_n,
  output logic [3:0]       we_n,
  output logic             xfer_ack,
  output logic             burst_refuse,
  output logic             ext_go,
  output logic [1:0]       ext_msel,
  output logic             bus_err
);

  localparam int CW = $clog2(MISS_CYCLES + 1);
  localparam int VALID_BIT = 0;
  localparam int MSEL_LSB = 6;
  localparam int BI_BIT = 8;

  typedef enum logic [2:0] {S_IDLE, S_GP1, S_GP2, S_EXT, S_MISS} state_t;

  logic [AW-1:PAGE_LSB] base_q [NBANK];
  logic [AW-1:PAGE_LSB] mask_q [NBANK];
  logic [1:0]           msel_q [NBANK];
  logic [NBANK-1:0]     valid_q, bi_q, hit;

  state_t          st;
  logic [IDXW-1:0] sel, bank_q;
  logic            any_hit, wr_q, refuse_q, go_q;
  logic [3:0]      lanes_q;
  logic [1:0]      msel_lat;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        msel_q[i] <= '0;
      end
      valid_q <= '0;
      bi_q    <= '0;
    end else if (cfg_we) begin
      if (cfg_opt) begin
        mask_q[cfg_idx] <= cfg_wdata[AW-1:PAGE_LSB];
        bi_q[cfg_idx]   <= cfg_wdata[BI_BIT];
      end else begin
        base_q[cfg_idx]  <= cfg_wdata[AW-1:PAGE_LSB];
        msel_q[cfg_idx]  <= cfg_wdata[MSEL_LSB+1:MSEL_LSB];
        valid_q[cfg_idx] <= cfg_wdata[VALID_BIT];
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_cmp
    assign hit[g] = valid_q[g] &&
                    (((req_addr[AW-1:PAGE_LSB] ^ base_q[g]) & mask_q[g]) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (hit[i]) sel = IDXW'(i);
  end
  assign any_hit = |hit;

  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    case (size)
      2'd0:    lane_mask = 4'b1000 >> off;
      2'd1:    lane_mask = off[1] ? 4'b0011 : 4'b1100;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bank_q   <= '0;
      wr_q     <= 1'b0;
      refuse_q <= 1'b0;
      go_q     <= 1'b0;
      lanes_q  <= '0;
      msel_lat <= '0;
      cnt      <= '0;
    end else begin
      go_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          bank_q   <= sel;
          wr_q     <= req_write;
          lanes_q  <= lane_mask(req_size, req_addr[1:0]);
          refuse_q <= req_burst && bi_q[sel];
          msel_lat <= msel_q[sel];
          cnt      <= '0;
          if (!any_hit)
            st <= S_MISS;
          else if (msel_q[sel] == 2'b00)
            st <= S_GP1;
          else begin
            st   <= S_EXT;
            go_q <= 1'b1;
          end
        end
        S_GP1: st <= S_GP2;
        S_GP2: st <= S_IDLE;
        S_EXT: if (ext_done) st <= S_IDLE;
        S_MISS:
          if (cnt == CW'(MISS_CYCLES - 1)) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic gp, active;
  assign gp     = (st == S_GP1) || (st == S_GP2);
  assign active = gp || (st == S_EXT);

  assign cs_n         = ~(active ? (NBANK'(1) << bank_q) : '0);
  assign oe_n         = !(gp && !wr_q);
  assign we_n         = ~((gp && wr_q) ? lanes_q : 4'b0000);
  assign xfer_ack     = (st == S_GP2);
  assign burst_refuse = (st == S_GP2) && refuse_q;
  assign ext_go       = (st == S_EXT) && go_q;
  assign ext_msel     = (st == S_EXT) ? msel_lat : 2'b00;
  assign bus_err      = (st == S_MISS) && (cnt == CW'(MISS_CYCLES - 1));

endmodule

// File: rtl/bank_select_ctrl_chk.sv
module bank_select_ctrl_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] cs_n,
  input logic             oe_n,
  input logic [3:0]       we_n,
  input logic             xfer_ack,
  input logic             burst_refuse,
  input logic             ext_go,
  input logic             bus_err
);

  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !(&we_n)));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  a_r7_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> (&cs_n));

  a_r7_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((!oe_n || !(&we_n)) && !xfer_ack) |=> xfer_ack);

  a_r8_refuse_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    burst_refuse |-> xfer_ack);

  a_r9_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_go |=> !ext_go);

  a_r9_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ext_go |-> (oe_n && (&we_n) && !xfer_ack && !(&cs_n)));

  a_r10_err_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (&cs_n));

  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

endmodule

bind bank_select_ctrl bank_select_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .xfer_ack(xfer_ack), .burst_refuse(burst_refuse), .ext_go(ext_go),
  .bus_err(bus_err)
);

// File: tb/tb_bank_select_ctrl.sv
module tb_bank_select_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_opt = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0, req_burst = 0, ext_done = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [7:0] cs_n;
  logic oe_n, xfer_ack, burst_refuse, ext_go, bus_err;
  logic [3:0] we_n;
  logic [1:0] ext_msel;

  always #10 clk = ~clk;

  bank_select_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opt(cfg_opt), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
    .ext_done(ext_done), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .xfer_ack(xfer_ack),
    .burst_refuse(burst_refuse), .ext_go(ext_go), .ext_msel(ext_msel), .bus_err(bus_err)
  );

  typedef struct packed {
    logic [7:0] cs_n;
    logic       oe_n;
    logic [3:0] we_n;
    logic       ack;
    logic       refuse;
    logic       go;
    logic [1:0] msel;
    logic       err;
  } exp_t;

  localparam exp_t IDLE = '{cs_n: 8'hFF, oe_n: 1'b1, we_n: 4'hF, ack: 1'b0,
                            refuse: 1'b0, go: 1'b0, msel: 2'b00, err: 1'b0};

  exp_t exp_q[$];
  logic [31:0] m_base [8];
  logic [31:0] m_opt [8];
  int checks = 0, errors = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE;
    cmp("R4", "cs_n", cs_n, e.cs_n);
    cmp("R5", "oe_n", oe_n, e.oe_n);
    cmp("R6", "we_n", we_n, e.we_n);
    cmp("R7", "xfer_ack", xfer_ack, e.ack);
    cmp("R8", "burst_refuse", burst_refuse, e.refuse);
    cmp("R9", "ext_go", ext_go, e.go);
    cmp("R9", "ext_msel", ext_msel, e.msel);
    cmp("R10", "bus_err", bus_err, e.err);
  endtask

  function automatic int decode(logic [31:0] a);
    for (int b = 0; b < 8; b++) begin
      logic [31:0] mk;
      mk = {m_opt[b][31:12], 12'h000};
      if (m_base[b][0] && ((a & mk) == ({m_base[b][31:12], 12'h000} & mk)))
        return b;
    end
    return -1;
  endfunction

  function automatic logic [3:0] lanes_of(logic [31:0] a, logic [1:0] size);
    int n;
    logic [3:0] l;
    n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    l = 0;
    for (int k = 0; k < 4; k++)
      if (k >= (a[1:0] / n) * n && k < (a[1:0] / n) * n + n)
        l[3 - k] = 1'b1;
    return l;
  endfunction

  // R1: register writes through the configuration port
  task automatic wr_cfg(int idx, bit opt, logic [31:0] d);
    cfg_we = 1; cfg_opt = opt; cfg_idx = idx[2:0]; cfg_wdata = d;
    if (opt) m_opt[idx] = d; else m_base[idx] = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic set_bank(int idx, logic [31:0] base, logic [31:0] mask,
                          logic [1:0] msel, bit valid, bit bi);
    wr_cfg(idx, 0, {base[31:12], 4'h0, msel, 5'h0, valid});
    wr_cfg(idx, 1, {mask[31:12], 3'h0, bi, 8'h0});
  endtask

  task automatic access(logic [31:0] a, bit wr, logic [1:0] size, bit burst,
                        int ext_len, bit intrude);
    int b;
    exp_t e;
    b = decode(a);
    if (b < 0) begin
      for (int k = 0; k < 16; k++) begin
        e = IDLE;
        e.err = (k == 15);
        exp_q.push_back(e);
      end
    end else if (m_base[b][7:6] == 2'b00) begin
      for (int k = 0; k < 2; k++) begin
        e = IDLE;
        e.cs_n = ~(8'h01 << b);
        e.oe_n = wr;
        e.we_n = wr ? ~lanes_of(a, size) : 4'hF;
        e.ack = (k == 1);
        e.refuse = (k == 1) && burst && m_opt[b][8];
        exp_q.push_back(e);
      end
    end else begin
      for (int k = 0; k < ext_len; k++) begin
        e = IDLE;
        e.cs_n = ~(8'h01 << b);
        e.go = (k == 0);
        e.msel = m_base[b][7:6];
        exp_q.push_back(e);
      end
    end
    req_valid = 1; req_addr = a; req_write = wr; req_size = size; req_burst = burst;
    tick();
    req_valid = 0;
    if (b < 0) begin
      repeat (15) tick();
    end else if (m_base[b][7:6] == 2'b00) begin
      if (intrude) begin
        // R11: second request while the first is running
        req_valid = 1; req_addr = 32'h2000_0000; req_write = 0;
      end
      tick();
      req_valid = 0;
    end else begin
      repeat (ext_len - 1) tick();
      ext_done = 1;
      tick();
      ext_done = 0;
    end
    tick();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_opt[i] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 / R10: after reset no bank is valid, so any address times out
    access(32'h0000_0000, 0, 2, 0, 0, 0);

    set_bank(0, 32'h0000_0000, 32'hFFF0_0000, 2'b00, 1, 1);
    set_bank(1, 32'h1000_0000, 32'hF000_0000, 2'b00, 1, 0);
    set_bank(2, 32'h1000_0000, 32'hFFFF_F000, 2'b01, 1, 0);
    set_bank(3, 32'h2000_0000, 32'hFF00_0000, 2'b10, 1, 0);
    set_bank(4, 32'h3000_0000, 32'hFF00_0000, 2'b00, 0, 1);
    set_bank(5, 32'h5000_0000, 32'hF000_0000, 2'b01, 1, 0);
    set_bank(6, 32'h5000_0000, 32'hFF00_0000, 2'b00, 1, 1);
    set_bank(7, 32'h4000_0000, 32'hFFFF_0000, 2'b11, 1, 0);

    // R5 R6: every size and byte offset, read and write
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        access(32'h0000_1000 | o, 1, s[1:0], 0, 0, 0);
        access(32'h0000_2000 | o, 0, s[1:0], 0, 0, 0);
      end
    access(32'h0000_0000, 1, 3, 0, 0, 0);
    // R2: low address bits and unmasked bits do not matter
    access(32'h000F_FFFF, 0, 2, 0, 0, 0);
    access(32'h1ABC_DFFF, 1, 0, 0, 0, 0);
    // R3: overlapping banks, lowest index wins
    access(32'h1000_0000, 0, 2, 0, 0, 0);
    access(32'h5000_0004, 0, 2, 0, 3, 0);
    // R2: invalid bank and unclaimed address
    access(32'h3000_0000, 0, 2, 0, 0, 0);
    access(32'h0010_0000, 1, 2, 0, 0, 0);
    // R8: bursts with and without the inhibit bit
    access(32'h0000_0100, 0, 2, 1, 0, 0);
    access(32'h1000_0100, 0, 2, 1, 0, 0);
    access(32'h0000_0100, 1, 2, 1, 0, 0);
    // R9: external sequencer accesses of several lengths
    access(32'h2000_0000, 0, 2, 0, 1, 0);
    access(32'h2012_3456, 1, 2, 0, 4, 0);
    access(32'h4000_FFFC, 0, 2, 0, 2, 0);
    // R11: request while busy is ignored
    access(32'h0000_0040, 0, 2, 0, 0, 1);
    access(32'h0000_0044, 1, 1, 0, 0, 1);
    // R1: reprogram a bank and use the new decode
    set_bank(0, 32'h0000_0000, 32'hFFF0_0000, 2'b10, 1, 1);
    access(32'h0000_0000, 0, 2, 0, 2, 0);
    repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule